// File: doc/BRIEF.md
# SPI Configuration Register Slave with Status Byte

This block is the serial front end of a radio-style peripheral. An SPI master (mode 0) opens a transaction by lowering chip select and sending a header byte that selects read or write, single or burst access, and a 6-bit register address. The block serves a bank of 47 byte-wide configuration registers at addresses 0x00 to 0x2E. Every register can be written and read, and each one drives the parallel `cfg_o` bus.

While each header byte is shifted in, and while each data byte of a write is shifted in, the block shifts a status byte out on MISO. The status byte carries three things. The first is a not-ready flag taken from the oscillator-stable input. The second is the 3-bit main-state code from the radio core. The third is a FIFO count saturated to four bits. On reads that count is the readable RX bytes, and on writes it is the free TX space.

A burst access walks a local address counter forward after every data byte. A single access ends after one data byte, and the next byte is taken as a fresh header. All SPI pins pass through two-flop synchronizers into the system clock domain.

Top module: `spi_cfg_slave`

## Requirements
- R1: Header bits, MSB first: bit 7 selects the direction (1 = read, 0 = write), bit 6 is the burst flag, and bits 5:0 are the address.
- R2: The status byte is {not_ready, state_i[2:0], fifo[3:0]}. not_ready is 1 until `xosc_stable_i` is high, and the state code is passed through unchanged for all eight values (0 idle, 1 rx, 2 tx, 3 fast-tx-ready, 4 calibrate, 5 settling, 6 rx overflow, 7 tx underflow).
- R3: The fifo field is `rx_count_i` when the header's direction bit is 1 and `tx_free_i` when it is 0. Any count of 15 or more reads as 15.
- R4: During a write, MISO carries the status byte for the header and for every data byte. The addressed register takes the data byte once its 8th bit has been sampled.
- R5: During a read, MISO carries the status byte for the header only, then the register contents MSB first.
- R6: In a burst, the address rises by one after each data byte, and after 0x2E it wraps to 0x00.
- R7: Addresses 0x2F to 0x3F hold no register. Writes to them change nothing, and reads from them return 0x00. A burst passing 0x3F wraps to 0x00.
- R8: Raising chip select aborts the transaction. A partly shifted byte is dropped, and the next byte after chip select falls again is a header.
- R9: MISO changes only while SCLK is low. While chip select is low and before the first SCLK edge, MISO shows the not_ready flag.
- R10: Reset clears every register to 0x00.
- R11: After the one data byte of a single access, the next byte within the same chip-select window is decoded as a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock (mode 0) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| xosc_stable_i | input | 1 | Oscillator has settled |
| state_i | input | 3 | Main state code from radio core |
| rx_count_i | input | CW | Bytes readable in RX FIFO |
| tx_free_i | input | CW | Bytes free in TX FIFO |
| cfg_o | output | NREG*8 | All configuration registers, register n at bits [8n+7:8n] |

## Verification
The hardest cases to reach are the ones where framing state and address state interact inside one chip-select window. These are a burst that crosses both wrap points, a data byte cut off mid-shift, and a single access followed at once by another header. The stimulus reaches them with bursts that start at 0x2D and at 0x3E. It also sends a write header followed by five stray bits and then a chip-select release, which must leave the register untouched, and it chains a single write and a read of the same register with no release between them. A sweep over all eight state codes, with rising RX counts, drives the fifo field through its saturation point.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int DW   = 8;
  localparam int AW   = 6;
  localparam int BITW = 3;

  typedef enum logic [2:0] {
    MS_IDLE    = 3'd0,
    MS_RX      = 3'd1,
    MS_TX      = 3'd2,
    MS_FTX_RDY = 3'd3,
    MS_CAL     = 3'd4,
    MS_SETTLE  = 3'd5,
    MS_RX_OVF  = 3'd6,
    MS_TX_UNF  = 3'd7
  } main_state_e;

  typedef struct packed {
    logic          rw;
    logic          burst;
    logic [AW-1:0] addr;
  } hdr_t;

  function automatic logic [3:0] sat_cnt(input logic [15:0] c);
    return (c > 16'd15) ? 4'hF : c[3:0];
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int NREG = 47,
  parameter int DW   = 8,
  parameter int AW   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i))     regs_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) < NREG) rd_data_o = regs_q[rd_addr_i];
  end

  assign regs_o = regs_q;

  AST_NO_WR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_addr_i) >= NREG) |=> $stable(regs_q)); // R7
  AST_CHANGE_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_q) |-> $past(wr_en_i)); // R4
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_cfg_pkg::*;
#(
  parameter int CW   = 7,
  parameter int LAST = 46
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_s_i,
  input  logic          cs_n_s_i,
  input  logic          mosi_s_i,
  input  logic          ready_i,
  input  logic [2:0]    state_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic [CW-1:0] tx_free_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          miso_o
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST);

  logic            sclk_q;
  logic [BITW-1:0] bit_cnt;
  logic            hdr_phase, rw_q, burst_q, mo_q;
  logic [AW-1:0]   addr_q, addr_n;
  logic [DW-2:0]   rx_sh;
  logic [DW-1:0]   rx_byte, rdata_q, status, out_byte;
  logic            rise, byte_done;
  hdr_t            hdr;

  assign rise      = sclk_s_i & ~sclk_q & ~cs_n_s_i;
  assign byte_done = rise & (bit_cnt == '1);
  assign rx_byte   = {rx_sh, mosi_s_i};
  assign hdr       = hdr_t'(rx_byte);

  always_comb begin
    if (hdr_phase)    addr_n = hdr.addr;
    else if (burst_q) addr_n = (addr_q == LAST_A) ? '0 : addr_q + 1'b1;
    else              addr_n = addr_q;
  end

  // fifo field follows direction bit captured on first header bit
  assign status   = {~ready_i, state_i, sat_cnt(16'(rw_q ? rx_cnt_i : tx_free_i))};
  assign out_byte = (hdr_phase || !rw_q) ? status : rdata_q;

  assign rd_addr_o = addr_n;
  assign wr_en_o   = byte_done & ~hdr_phase & ~rw_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = rx_byte;
  assign miso_o    = mo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      hdr_phase <= 1'b1;
      rw_q      <= 1'b0;
      burst_q   <= 1'b0;
      addr_q    <= '0;
      rx_sh     <= '0;
      rdata_q   <= '0;
      mo_q      <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      if (cs_n_s_i) begin
        bit_cnt   <= '0;
        hdr_phase <= 1'b1;
        mo_q      <= ~ready_i;
      end else begin
        if (!sclk_s_i) mo_q <= out_byte[~bit_cnt];
        if (rise) begin
          rx_sh   <= rx_byte[DW-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (hdr_phase && bit_cnt == '0) rw_q <= mosi_s_i;
          if (byte_done) begin
            if (hdr_phase) begin
              rw_q      <= hdr.rw;
              burst_q   <= hdr.burst;
              addr_q    <= addr_n;
              rdata_q   <= rd_data_i;
              hdr_phase <= 1'b0;
            end else if (burst_q) begin
              addr_q  <= addr_n;
              rdata_q <= rd_data_i;
            end else begin
              hdr_phase <= 1'b1;
            end
          end
        end
      end
    end
  end

  AST_CS_HIGH_REFRAMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> (bit_cnt == '0 && hdr_phase)); // R8
  AST_MISO_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_s_i && sclk_s_i && sclk_q) |=> $stable(mo_q)); // R9
  AST_BURST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !hdr_phase && burst_q && addr_q == LAST_A) |=> addr_q == '0); // R6
  AST_SINGLE_REHDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !hdr_phase && !burst_q) |=> hdr_phase); // R11
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NREG = 47,
  parameter int CW   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  input  logic               xosc_stable_i,
  input  logic [2:0]         state_i,
  input  logic [CW-1:0]      rx_count_i,
  input  logic [CW-1:0]      tx_free_i,
  output logic [NREG*DW-1:0] cfg_o
);
  localparam int LAST = NREG - 1;

  logic [3:0]    sync_q;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  // order: xosc, mosi, cs_n, sclk
  spi_sync #(.W(4), .RST_VAL(4'b0010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({xosc_stable_i, mosi_i, cs_ni, sclk_i}),
    .q_o    (sync_q)
  );

  spi_frame #(.CW(CW), .LAST(LAST)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sync_q[0]),
    .cs_n_s_i  (sync_q[1]),
    .mosi_s_i  (sync_q[2]),
    .ready_i   (sync_q[3]),
    .state_i   (state_i),
    .rx_cnt_i  (rx_count_i),
    .tx_free_i (tx_free_i),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .miso_o    (miso_o)
  );

  cfg_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (cfg_o)
  );
endmodule

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/1ps
module tb_spi_cfg_slave;
  localparam int NREG = 47;
  localparam int CW   = 7;
  localparam int HALF = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, xosc = 1'b0;
  logic [2:0] state = 3'd0;
  logic [CW-1:0] rx_cnt = '0, tx_free = '0;
  logic miso;
  logic [NREG*8-1:0] cfg;

  int checks = 0, errors = 0;
  logic [7:0] model [64];

  typedef struct {logic [7:0] val; string tag;} exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  spi_cfg_slave #(.NREG(NREG), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .xosc_stable_i(xosc), .state_i(state),
    .rx_count_i(rx_cnt), .tx_free_i(tx_free), .cfg_o(cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input logic rw);
    logic [CW-1:0] c = rw ? rx_cnt : tx_free;
    return {~xosc, state, (c > 15) ? 4'hF : c[3:0]};
  endfunction

  task automatic shift_byte(input logic [7:0] mo, input logic [7:0] ex, input string tag);
    q.push_back('{ex, tag});
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i]; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
  endtask

  task automatic shift_bits(input logic [7:0] mo, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = mo[i]; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; #200; endtask
  task automatic cs_hi(); #100; cs_n = 1'b1; #300; endtask

  task automatic wr_burst(input logic [5:0] a, input logic [7:0] d [], input string tag);
    logic [5:0] p = a;
    cs_lo();
    shift_byte({2'b01, a}, st(1'b0), tag);
    foreach (d[k]) begin
      shift_byte(d[k], st(1'b0), tag);
      if (p < NREG) model[p] = d[k];
      p = (p == 6'(NREG - 1)) ? 6'd0 : p + 6'd1;
    end
    cs_hi();
  endtask

  task automatic rd_burst(input logic [5:0] a, input int n, input string tag);
    logic [5:0] p = a;
    cs_lo();
    shift_byte({2'b11, a}, st(1'b1), tag);
    for (int k = 0; k < n; k++) begin
      shift_byte(8'h00, model[p], tag);
      p = (p == 6'(NREG - 1)) ? 6'd0 : p + 6'd1;
    end
    cs_hi();
  endtask

  task automatic check_cfg(input string req);
    for (int a = 0; a < NREG; a++) chk(req, 32'(cfg[a*8 +: 8]), 32'(model[a]));
  endtask

  // monitor: rebuilds each MISO byte on master sample edges, compares against queue
  initial begin
    int cnt;
    logic [7:0] sh;
    exp_t e;
    cnt = 0; sh = '0;
    forever begin
      @(posedge sclk or posedge cs_n);
      if (cs_n) cnt = 0;
      else begin
        sh = {sh[6:0], miso};
        cnt++;
        if (cnt == 8) begin
          cnt = 0;
          if (q.size() == 0) chk("R4/R5 unexpected byte", 32'(sh), 32'hFFFF_FFFF);
          else begin
            e = q.pop_front();
            chk(e.tag, 32'(sh), 32'(e.val));
          end
        end
      end
    end
  end

  initial begin
    #2ms;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 8'h00;
    #33 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state, R2 not-ready on MISO
    chk("R10 reset cfg zero", 32'(cfg == '0), 32'd1);
    chk("R2 not_ready idle", 32'(miso), 32'd1);

    // R9 MISO shows ready flag before first edge
    cs_lo();
    chk("R9 ready flag before clock (not ready)", 32'(miso), 32'd1);
    xosc = 1'b1; #100;
    chk("R9 ready flag before clock (ready)", 32'(miso), 32'd0);
    cs_hi();
    xosc = 1'b0; #100;
    state = 3'd1; rx_cnt = 7'd20; tx_free = 7'd3;
    rd_burst(6'h05, 0, "R2 status with not_ready set");
    xosc = 1'b1; #100;

    // R1 R4 single write, R3 tx free count
    begin
      logic [7:0] d[] = '{8'hA5};
      cs_lo();
      shift_byte(8'h05, st(1'b0), "R4 R3 write header status");
      shift_byte(8'hA5, st(1'b0), "R4 write data status");
      model[5] = 8'hA5;
      cs_hi();
      chk("R4 R1 reg5 written", 32'(cfg[5*8 +: 8]), 32'hA5);
      d = '{8'h11};
    end

    // R5 R3 single read with saturated rx count
    cs_lo();
    shift_byte(8'h85, st(1'b1), "R3 read header saturated");
    shift_byte(8'h00, 8'hA5, "R5 read data");
    cs_hi();

    // R6 burst write wrapping past last register
    tx_free = 7'd40; state = 3'd2;
    wr_burst(6'h2C, '{8'h21, 8'h32, 8'h43, 8'h54}, "R6 burst write status");
    check_cfg("R6 burst write contents");
    rd_burst(6'h2D, 4, "R6 burst read wrap");

    // R7 unmapped addresses
    wr_burst(6'h30, '{8'hFF}, "R7 write unmapped status");
    check_cfg("R7 unmapped write ignored");
    rd_burst(6'h30, 1, "R7 read unmapped");
    rd_burst(6'h3E, 3, "R7 burst across 0x3F");

    // R8 abort mid data byte
    cs_lo();
    shift_byte(8'h02, st(1'b0), "R8 header before abort");
    shift_bits(8'hFF, 5);
    cs_hi();
    chk("R8 aborted byte not written", 32'(cfg[2*8 +: 8]), 32'(model[2]));
    rd_burst(6'h02, 1, "R8 reframed header after abort");

    // R11 back-to-back single accesses in one window
    cs_lo();
    shift_byte(8'h01, st(1'b0), "R11 write header");
    shift_byte(8'h3C, st(1'b0), "R11 write data");
    model[1] = 8'h3C;
    shift_byte(8'h81, st(1'b1), "R11 second header status");
    shift_byte(8'h00, 8'h3C, "R11 second header read data");
    cs_hi();

    // R2 R3 sweep state codes and rx counts
    for (int s = 0; s < 8; s++) begin
      state = 3'(s); rx_cnt = 7'(s * 3);
      rd_burst(6'h05, 1, "R2 R3 state sweep");
    end

    #500;
    chk("R4 R5 all expected bytes seen", 32'(q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule